// File: doc/BRIEF.md
# Interrupt Gate Descriptor Lookup Unit

This unit turns an 8-bit interrupt vector into a dispatch decision. It reads one 8-byte gate descriptor from a table in memory. The table base is a 32-bit linear address. The table limit is held as the table size in bytes minus one. Software writes both values through a load port. Each request carries three things: the vector, a flag that says whether software or hardware raised it, and the current privilege level.

For each request the unit works out the entry address from the base and the vector scaled by eight. It checks that the whole entry lies inside the limit. It then fetches the descriptor over a valid/ready read port and decodes the gate type. The result is one of two things. The first is a dispatch: the target selector, the entry offset, the gate kind, whether the interrupt flag must be cleared, whether the entry runs in 16-bit mode, and whether a task switch is requested. The second is a fault: a fault code with the vector as its error index.

The unit handles one lookup at a time. Stack pushes, the task switch itself, and checks of the target segment belong to the consumer of the result.

Top module: `idt_gate_lookup`

## Requirements
- R1: The descriptor read address equals the loaded base plus the vector times 8, wrapping at 32 bits. Vector 0 is an ordinary usable entry.
- R2: If vector*8+7 is greater than the loaded limit, the result is a fault with code 0 and no memory read is issued. In any fault result, selector, offset, kind, flag-clear, task-switch and 16-bit outputs are all zero.
- R3: A descriptor whose present bit (bit 47) is clear gives a fault with code 1. This check has priority over the type and privilege checks.
- R4: Bits 44..40 of the descriptor form a 5-bit type. Only 0x05, 0x06, 0x07, 0x0E and 0x0F are defined; any other value gives a fault with code 2. A set bit 44 is therefore a fault.
- R5: A software request whose privilege level is numerically greater than the descriptor privilege level (bits 46..45) gives a fault with code 3. Hardware requests skip this check.
- R6: Types 0x06 and 0x0E are interrupt gates: kind is 0 and flag-clear is 1. Types 0x07 and 0x0F are trap gates: kind is 1 and flag-clear is 0.
- R7: Type 0x05 is a task gate. It gives kind 2, task-switch 1, the descriptor selector, an offset of zero, and flag-clear 0.
- R8: Types 0x06 and 0x07 set the 16-bit output and give the offset from bits 15..0 only. Types 0x0E and 0x0F give the 32-bit offset {bits 63..48, bits 15..0}.
- R9: On a dispatch, the selector output is descriptor bits 31..16, and the vector output always equals the requested vector.
- R10: A request is accepted only while busy is low. Busy is high from the cycle after acceptance until the result cycle ends, and requests presented while busy are ignored. A read request holds its address until ready is seen.
- R11: The result is valid for exactly one cycle. It appears in the cycle after the response beat, or in the cycle after acceptance for a limit fault.
- R12: A base or limit loaded while a lookup is in progress does not change that lookup. It applies from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tbl_load_i | input | 1 | Load base and limit |
| tbl_base_i | input | 32 | Table linear base address |
| tbl_limit_i | input | 16 | Table size in bytes minus one |
| req_valid_i | input | 1 | Lookup request |
| req_vec_i | input | 8 | Interrupt vector |
| req_soft_i | input | 1 | 1 = software-raised, 0 = hardware |
| req_cpl_i | input | 2 | Current privilege level |
| busy_o | output | 1 | Lookup in progress; requests ignored |
| mem_rd_valid_o | output | 1 | Descriptor read request |
| mem_rd_ready_i | input | 1 | Read request accepted |
| mem_rd_addr_o | output | 32 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Read data beat |
| mem_rsp_data_i | input | 64 | Descriptor |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_fault_o | output | 1 | Result is a fault |
| res_fault_code_o | output | 2 | 0 limit, 1 absent, 2 bad type, 3 privilege |
| res_vec_o | output | 8 | Vector of this result (fault error index) |
| res_sel_o | output | 16 | Target selector |
| res_offset_o | output | 32 | Entry offset |
| res_kind_o | output | 2 | 0 interrupt, 1 trap, 2 task |
| res_if_clear_o | output | 1 | Clear the interrupt flag on dispatch |
| res_task_sw_o | output | 1 | Task switch requested |
| res_mode16_o | output | 1 | Entry runs in 16-bit protected mode |

## Verification
The bench builds the unit with its default widths: a 32-bit base, a 16-bit limit and an 8-bit vector. With these widths the full 256-entry range is reachable. The bench also shrinks the limit to ten entries, which puts the exact boundary at vector 9 versus vector 10 and tests vector 255 against a short table. The read-ready line stalls in a repeating pattern, so the unit must hold its request across stalls. A base reload in the middle of a lookup and requests raised while busy show that in-flight state is isolated.

// File: rtl/idt_pkg.sv
package idt_pkg;
  localparam int DESC_W = 64;
  localparam int SEL_W  = 16;
  localparam int OFS_W  = 32;

  typedef enum logic [1:0] {
    GK_INTR = 2'd0,
    GK_TRAP = 2'd1,
    GK_TASK = 2'd2
  } gate_kind_e;

  typedef enum logic [1:0] {
    FC_LIMIT  = 2'd0,
    FC_ABSENT = 2'd1,
    FC_TYPE   = 2'd2,
    FC_PRIV   = 2'd3
  } fault_code_e;

  typedef struct packed {
    logic             fault;
    fault_code_e      code;
    logic [SEL_W-1:0] sel;
    logic [OFS_W-1:0] offset;
    gate_kind_e       kind;
    logic             if_clear;
    logic             task_sw;
    logic             mode16;
  } gate_res_t;
endpackage

// File: rtl/idt_entry_addr.sv
module idt_entry_addr #(
  parameter int ADDR_W  = 32,
  parameter int LIM_W   = 16,
  parameter int VEC_W   = 8,
  parameter int ENT_LG2 = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              over_o
);
  localparam int IDX_W = VEC_W + ENT_LG2;
  localparam int CMP_W = (IDX_W > LIM_W) ? IDX_W : LIM_W;

  logic [IDX_W-1:0] first_b, last_b;
  logic [CMP_W-1:0] last_x, lim_x;

  assign first_b = {vec_i, {ENT_LG2{1'b0}}};
  assign last_b  = {vec_i, {ENT_LG2{1'b1}}};
  assign last_x  = CMP_W'(last_b);
  assign lim_x   = CMP_W'(limit_i);
  assign over_o  = last_x > lim_x;
  assign addr_o  = base_i + ADDR_W'(first_b);
endmodule

// File: rtl/idt_gate_decode.sv
module idt_gate_decode
  import idt_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  input  logic              soft_i,
  input  logic [1:0]        cpl_i,
  output gate_res_t         res_o
);
  logic [4:0]       gtype;
  logic [1:0]       dpl;
  logic             present;
  logic [OFS_W-1:0] ofs32;

  assign gtype   = desc_i[44:40];
  assign dpl     = desc_i[46:45];
  assign present = desc_i[47];
  assign ofs32   = {desc_i[63:48], desc_i[15:0]};

  always_comb begin
    gate_res_t d;
    logic      known;
    d     = '0;
    known = 1'b1;
    unique case (gtype)
      5'h05: begin d.kind = GK_TASK; d.task_sw = 1'b1; end
      5'h06: begin d.kind = GK_INTR; d.if_clear = 1'b1; d.mode16 = 1'b1;
                   d.offset = {16'h0, desc_i[15:0]}; end
      5'h07: begin d.kind = GK_TRAP; d.mode16 = 1'b1;
                   d.offset = {16'h0, desc_i[15:0]}; end
      5'h0E: begin d.kind = GK_INTR; d.if_clear = 1'b1; d.offset = ofs32; end
      5'h0F: begin d.kind = GK_TRAP; d.offset = ofs32; end
      default: known = 1'b0;
    endcase
    d.sel = desc_i[31:16];
    if (!present || !known || (soft_i && (cpl_i > dpl))) begin
      d       = '0;
      d.fault = 1'b1;
      if (!present)    d.code = FC_ABSENT;
      else if (!known) d.code = FC_TYPE;
      else             d.code = FC_PRIV;
    end
    res_o = d;
  end
endmodule

// File: rtl/idt_gate_lookup.sv
module idt_gate_lookup
  import idt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_load_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic [LIM_W-1:0]  tbl_limit_i,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  input  logic              req_soft_i,
  input  logic [1:0]        req_cpl_i,
  output logic              busy_o,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  output logic              res_valid_o,
  output logic              res_fault_o,
  output logic [1:0]        res_fault_code_o,
  output logic [VEC_W-1:0]  res_vec_o,
  output logic [15:0]       res_sel_o,
  output logic [31:0]       res_offset_o,
  output logic [1:0]        res_kind_o,
  output logic              res_if_clear_o,
  output logic              res_task_sw_o,
  output logic              res_mode16_o
);
  localparam int ENT_LG2 = $clog2(DESC_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RES} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] base_q, addr_q, addr_d;
  logic [LIM_W-1:0]  limit_q;
  logic [VEC_W-1:0]  vec_q;
  logic              soft_q;
  logic [1:0]        cpl_q;
  logic              over;
  logic              accept;
  gate_res_t         res_q, dec;

  idt_entry_addr #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .VEC_W(VEC_W), .ENT_LG2(ENT_LG2)
  ) u_addr (
    .base_i (base_q),
    .limit_i(limit_q),
    .vec_i  (req_vec_i),
    .addr_o (addr_d),
    .over_o (over)
  );

  idt_gate_decode u_dec (
    .desc_i(mem_rsp_data_i),
    .soft_i(soft_q),
    .cpl_i (cpl_q),
    .res_o (dec)
  );

  assign accept = req_valid_i && (state_q == S_IDLE);

  // table registers: snapshot into addr_q at accept isolates in-flight lookups
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (tbl_load_i) begin
      base_q  <= tbl_base_i;
      limit_q <= tbl_limit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      vec_q   <= '0;
      soft_q  <= 1'b0;
      cpl_q   <= '0;
      res_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          addr_q <= addr_d;
          vec_q  <= req_vec_i;
          soft_q <= req_soft_i;
          cpl_q  <= req_cpl_i;
          if (over) begin
            res_q       <= '0;
            res_q.fault <= 1'b1;
            res_q.code  <= FC_LIMIT;
            state_q     <= S_RES;
          end else begin
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rd_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          res_q   <= dec;
          state_q <= S_RES;
        end
        S_RES: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o           = state_q != S_IDLE;
  assign mem_rd_valid_o   = state_q == S_FETCH;
  assign mem_rd_addr_o    = addr_q;
  assign res_valid_o      = state_q == S_RES;
  assign res_fault_o      = res_q.fault;
  assign res_fault_code_o = res_q.code;
  assign res_vec_o        = vec_q;
  assign res_sel_o        = res_q.sel;
  assign res_offset_o     = res_q.offset;
  assign res_kind_o       = res_q.kind;
  assign res_if_clear_o   = res_q.if_clear;
  assign res_task_sw_o    = res_q.task_sw;
  assign res_mode16_o     = res_q.mode16;
endmodule

// File: rtl/idt_gate_lookup_chk.sv
module idt_gate_lookup_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              mem_rd_valid_o,
  input logic              mem_rd_ready_i,
  input logic [ADDR_W-1:0] mem_rd_addr_o,
  input logic              res_valid_o,
  input logic              res_fault_o,
  input logic              res_task_sw_o,
  input logic              res_if_clear_o,
  input logic              res_mode16_o,
  input logic [31:0]       res_offset_o
);
  assert_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_hold_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));

  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_valid_o && !res_valid_o);

  assert_task_no_ofs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_task_sw_o |-> res_offset_o == 32'h0 && !res_if_clear_o);

  assert_narrow_ofs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_mode16_o |-> res_offset_o[31:16] == 16'h0);

  assert_fault_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_fault_o |-> !res_task_sw_o && !res_if_clear_o && !res_mode16_o);
endmodule

bind idt_gate_lookup idt_gate_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .busy_o        (busy_o),
  .mem_rd_valid_o(mem_rd_valid_o),
  .mem_rd_ready_i(mem_rd_ready_i),
  .mem_rd_addr_o (mem_rd_addr_o),
  .res_valid_o   (res_valid_o),
  .res_fault_o   (res_fault_o),
  .res_task_sw_o (res_task_sw_o),
  .res_if_clear_o(res_if_clear_o),
  .res_mode16_o  (res_mode16_o),
  .res_offset_o  (res_offset_o)
);

// File: tb/sim_idt_gate_lookup.sv
`timescale 1ns/100ps
module sim_idt_gate_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_load = 1'b0;
  logic [31:0] tbl_base = '0;
  logic [15:0] tbl_limit = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vec = '0;
  logic        req_soft = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        busy;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        r_valid, r_fault, r_ifc, r_task, r_m16;
  logic [1:0]  r_code, r_kind;
  logic [7:0]  r_vec;
  logic [15:0] r_sel;
  logic [31:0] r_ofs;

  always #2.5 clk = ~clk;

  idt_gate_lookup u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_load_i(tbl_load), .tbl_base_i(tbl_base), .tbl_limit_i(tbl_limit),
    .req_valid_i(req_valid), .req_vec_i(req_vec), .req_soft_i(req_soft), .req_cpl_i(req_cpl),
    .busy_o(busy),
    .mem_rd_valid_o(rd_valid), .mem_rd_ready_i(rd_ready), .mem_rd_addr_o(rd_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .res_valid_o(r_valid), .res_fault_o(r_fault), .res_fault_code_o(r_code),
    .res_vec_o(r_vec), .res_sel_o(r_sel), .res_offset_o(r_ofs), .res_kind_o(r_kind),
    .res_if_clear_o(r_ifc), .res_task_sw_o(r_task), .res_mode16_o(r_m16)
  );

  typedef struct packed {
    logic        fault;
    logic [1:0]  code;
    logic [7:0]  vec;
    logic [15:0] sel;
    logic [31:0] ofs;
    logic [1:0]  kind;
    logic        ifc;
    logic        task_sw;
    logic        m16;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  string       tag_q[$];
  logic [63:0] mem[int unsigned];
  logic [31:0] m_base = '0;
  logic [15:0] m_limit = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic logic [63:0] mk(input logic [31:0] ofs, input logic [15:0] sel,
                                     input logic [4:0] t, input logic [1:0] dpl, input logic p);
    return {ofs[31:16], p, dpl, t, 8'h00, sel, ofs[15:0]};
  endfunction

  function automatic logic [63:0] rd_mem(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  function automatic exp_t predict(input logic [7:0] v, input logic s, input logic [1:0] c);
    exp_t        e;
    logic [63:0] d;
    logic [4:0]  t;
    e = '0;
    e.vec = v;
    if ({5'b0, v, 3'b111} > m_limit) begin e.fault = 1; e.code = 2'd0; return e; end
    d = rd_mem(m_base + {21'b0, v, 3'b000});
    t = d[44:40];
    if (!d[47]) begin e.fault = 1; e.code = 2'd1; return e; end
    if (!(t inside {5'h05, 5'h06, 5'h07, 5'h0E, 5'h0F})) begin e.fault = 1; e.code = 2'd2; return e; end
    if (s && (c > d[46:45])) begin e.fault = 1; e.code = 2'd3; return e; end
    e.sel = d[31:16];
    case (t)
      5'h05: begin e.kind = 2; e.task_sw = 1; end
      5'h06: begin e.kind = 0; e.ifc = 1; e.m16 = 1; e.ofs = {16'h0, d[15:0]}; end
      5'h07: begin e.kind = 1; e.m16 = 1; e.ofs = {16'h0, d[15:0]}; end
      5'h0E: begin e.kind = 0; e.ifc = 1; e.ofs = {d[63:48], d[15:0]}; end
      default: begin e.kind = 1; e.ofs = {d[63:48], d[15:0]}; end
    endcase
    return e;
  endfunction

  task automatic load_tbl(input logic [31:0] b, input logic [15:0] l);
    tbl_base = b; tbl_limit = l; tbl_load = 1;
    @(negedge clk);
    tbl_load = 0;
    m_base = b; m_limit = l;
  endtask

  task automatic issue(input logic [7:0] v, input logic s, input logic [1:0] c, input string tag);
    exp_t e;
    while (busy) @(negedge clk);
    e = predict(v, s, c);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (!(e.fault && e.code == 2'd0)) addr_q.push_back(m_base + {21'b0, v, 3'b000});
    req_vec = v; req_soft = s; req_cpl = c; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    n_chk++;
    if (!busy) begin n_bad++; $display("FAIL R10 busy after accept: got %b exp 1", busy); end
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder with a stall pattern on ready; checks R1 address
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      rd_ready = (k % 3) != 1;
      k++;
      if (rd_valid && rd_ready) begin
        logic [31:0] a;
        a = rd_addr;
        n_chk++;
        if (addr_q.size() == 0) begin
          n_bad++; $display("FAIL R2 unexpected read: got %h exp none", a);
        end else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          if (a !== ea) begin n_bad++; $display("FAIL R1 address: got %h exp %h", a, ea); end
        end
        @(negedge clk);
        rd_ready = 0;
        rsp_valid = 1;
        rsp_data = rd_mem(a);
        @(negedge clk);
        rsp_valid = 0;
        rsp_data = '0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && r_valid) begin
        exp_t  got, e;
        string tg;
        got = {r_fault, r_code, r_vec, r_sel, r_ofs, r_kind, r_ifc, r_task, r_m16};
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++; $display("FAIL R10 unexpected result: got %h exp none", got);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (!e.fault) got.code = 2'd0;
          if (got !== e) begin
            n_bad++; $display("FAIL %s vec %0d: got %h exp %h", tg, e.vec, got, e);
          end
        end
        @(negedge clk);
        n_chk++;
        if (r_valid) begin n_bad++; $display("FAIL R11 valid held: got 1 exp 0"); end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    mem[32'h0001_0000] = mk(32'hC000_1234, 16'h0008, 5'h0E, 2'd0, 1);  // v0 intr32
    mem[32'h0001_0018] = mk(32'h8765_4321, 16'h0010, 5'h0F, 2'd3, 1);  // v3 trap32
    mem[32'h0001_0028] = mk(32'hFFFF_FFFF, 16'h0028, 5'h05, 2'd3, 1);  // v5 task
    mem[32'h0001_0030] = mk(32'hABCD_5678, 16'h0018, 5'h06, 2'd0, 1);  // v6 intr16
    mem[32'h0001_0038] = mk(32'h1111_2222, 16'h0020, 5'h07, 2'd0, 1);  // v7 trap16
    mem[32'h0001_0040] = mk(32'h0000_1000, 16'h0008, 5'h0E, 2'd0, 0);  // v8 absent
    mem[32'h0001_0048] = mk(32'h0000_1000, 16'h0008, 5'h0C, 2'd0, 1);  // v9 bad type
    mem[32'h0001_0050] = mk(32'h0000_1000, 16'h0008, 5'h1E, 2'd0, 1);  // v10 bit44 set
    mem[32'h0001_0058] = mk(32'h0000_2000, 16'h0030, 5'h0E, 2'd0, 1);  // v11 dpl0
    mem[32'h0001_0060] = mk(32'h0000_3000, 16'h0008, 5'h0C, 2'd0, 0);  // v12 absent+bad
    mem[32'h0001_07F8] = mk(32'h0BAD_F00D, 16'h0038, 5'h0F, 2'd3, 1);  // v255
    mem[32'h0002_0000] = mk(32'h2222_0000, 16'h0040, 5'h0E, 2'd0, 1);  // alt table v0
    mem[32'h0002_0100] = mk(32'h3333_0000, 16'h0048, 5'h0F, 2'd0, 1);  // alt table v32

    repeat (3) @(negedge clk);
    n_chk++;
    if (busy !== 0 || r_valid !== 0 || rd_valid !== 0) begin
      n_bad++; $display("FAIL R10 reset state: got %b%b%b exp 000", busy, r_valid, rd_valid);
    end
    rst_n = 1;
    @(negedge clk);
    load_tbl(32'h0001_0000, 16'h07FF);

    issue(8'd0, 0, 2'd0, "R1_R6_R8_R9 vec0 intr32");
    issue(8'd3, 1, 2'd3, "R6_R8 trap32 soft");
    issue(8'd5, 1, 2'd3, "R7 task gate");
    issue(8'd6, 0, 2'd0, "R8_R6 intr16");
    issue(8'd7, 0, 2'd0, "R8_R6 trap16");
    issue(8'd8, 0, 2'd0, "R3 absent");
    issue(8'd9, 0, 2'd0, "R4 bad type");
    issue(8'd10, 0, 2'd0, "R4 bit44");
    issue(8'd11, 1, 2'd3, "R5 priv soft");
    issue(8'd11, 0, 2'd3, "R5 hw skips dpl");
    issue(8'd11, 1, 2'd0, "R5 soft equal dpl");
    issue(8'd12, 1, 2'd3, "R3 absent priority");
    issue(8'd255, 0, 2'd0, "R1 vec255 full table");
    wait_idle();

    load_tbl(32'h0001_0000, 16'h004F);
    issue(8'd9, 0, 2'd0, "R2 last entry inside");
    issue(8'd10, 0, 2'd0, "R2 first entry outside");
    issue(8'd255, 0, 2'd0, "R2 vec255 short table");
    wait_idle();

    // requests while busy are ignored
    load_tbl(32'h0001_0000, 16'h07FF);
    issue(8'd0, 0, 2'd0, "R10 before spurious");
    req_vec = 8'd3; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    wait_idle();

    // reload table during a lookup
    issue(8'd6, 0, 2'd0, "R12 in-flight keeps old base");
    tbl_base = 32'h0002_0000; tbl_limit = 16'h07FF; tbl_load = 1;
    @(negedge clk);
    tbl_load = 0;
    m_base = 32'h0002_0000; m_limit = 16'h07FF;
    issue(8'd32, 0, 2'd0, "R12 next uses new base");
    issue(8'd0, 0, 2'd0, "R12 new base vec0");
    wait_idle();
    repeat (4) @(negedge clk);

    n_chk++;
    if (exp_q.size() != 0 || addr_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11 pending: got %0d/%0d exp 0/0", exp_q.size(), addr_q.size());
    end
    finish_run();
  end
endmodule